// File: doc/BRIEF.md
# Strap-Latched Test Mode Controller

This block chooses the chip's operating mode at power-up. Three configuration strap pins are followed while the power-on reset input is low. Their values are frozen when that reset rises, so the same pins can return to their ordinary jobs afterwards. Two active-low test pins are never frozen. Each cycle the block combines them with the frozen straps to pick one of eight modes. The mode is given on a one-hot vector, together with a flag that marks the narrow (8-bit) boot.

The block also sits in the path of every pad output enable, for a parameterized number of pads. In system test it turns every pad output off, so the whole package floats. In pin test it turns on the drivers of the pads that are marked as input-only by a mask parameter. All other pads, and all pads in every other mode, pass their functional enable through unchanged.

Top module: `strap_test_mode`

## Requirements
- R1: `mode_o` is one-hot with the bit order 0 = wide boot, 1 = narrow boot, 2 = alternate ROM boot, 3 = clock bypass, 4 = functional test, 5 = clock test, 6 = pin test, 7 = system test.
- R2: With `ntest0_n`=1 and `ntest1_n`=1, the effective straps pick the boot mode: `boot_a`=1 gives bit 2 whatever `boot_b` is; `boot_a`=0 gives bit 0 when `boot_b`=0 and bit 1 when `boot_b`=1.
- R3: With `ntest0_n`=1 and `ntest1_n`=0, the mode is bit 3 whatever the straps are.
- R4: With `ntest0_n`=0 and `ntest1_n`=1, the mode is bit 4 when the effective `test_c` is 1 and bit 5 when it is 0.
- R5: With `ntest0_n`=0 and `ntest1_n`=0, the mode is bit 6 when the effective `test_c` is 1 and bit 7 when it is 0.
- R6: While `por_n` is low, the effective straps are the live values on `boot_a`, `boot_b` and `test_c`.
- R7: On the rising edge of `por_n` the straps are frozen. Later changes on the strap pins do not change `mode_o` or `boot_narrow_o` while `por_n` stays high.
- R8: The test pins are never frozen. After the straps are latched, a change on `ntest0_n` or `ntest1_n` changes the mode at once.
- R9: In system test, `pad_oe_o` is all zero.
- R10: In pin test, every pad whose bit in `IN_PAD_MASK` is 1 has `pad_oe_o`=1. Every other pad copies `pad_oe_i`.
- R11: In the six modes other than pin test and system test, `pad_oe_o` equals `pad_oe_i`.
- R12: `boot_narrow_o` is 1 exactly when `mode_o` bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low; its rising edge freezes the straps |
| boot_a | input | 1 | Strap: selects the alternate ROM boot |
| boot_b | input | 1 | Strap: selects the narrow boot |
| test_c | input | 1 | Strap: selects the sub-mode inside the test pairs |
| ntest0_n | input | 1 | Live test pin 0, active low |
| ntest1_n | input | 1 | Live test pin 1, active low |
| pad_oe_i | input | PADS | Functional output enables from the core |
| mode_o | output | 8 | One-hot mode vector |
| boot_narrow_o | output | 1 | High in the narrow boot mode |
| pad_oe_o | output | PADS | Output enables sent to the pads |

## Verification
The assertions check on every settled input combination that the mode is one-hot, that it matches the test-pin pair, and that the override follows the mode: all off in system test, masked pads forced in pin test, and pass-through elsewhere. Only the bench's scenarios can show that the straps are frozen at the reset edge and stay frozen. To show this, the bench raises the reset with known strap values, then toggles the strap pins and checks that the mode stays put while the test pins still steer it. It goes through several reset cycles that cover all eight strap combinations.

// File: rtl/strap_test_mode.sv
`timescale 1ns/1ps
module strap_test_mode #(
  parameter int PADS = 16,
  parameter logic [PADS-1:0] IN_PAD_MASK = 16'h0F0F
) (
  input  logic            por_n,
  input  logic            boot_a,
  input  logic            boot_b,
  input  logic            test_c,
  input  logic            ntest0_n,
  input  logic            ntest1_n,
  input  logic [PADS-1:0] pad_oe_i,
  output logic [7:0]      mode_o,
  output logic            boot_narrow_o,
  output logic [PADS-1:0] pad_oe_o
);

  logic [2:0] strap_q;
  logic [2:0] strap_eff;

  always_ff @(posedge por_n)
    strap_q <= {test_c, boot_b, boot_a};

  assign strap_eff = por_n ? strap_q : {test_c, boot_b, boot_a};

  always_comb begin
    mode_o = 8'b0;
    unique case ({ntest0_n, ntest1_n})
      2'b11: begin
        if (strap_eff[0])      mode_o[2] = 1'b1;
        else if (strap_eff[1]) mode_o[1] = 1'b1;
        else                   mode_o[0] = 1'b1;
      end
      2'b10: mode_o[3] = 1'b1;
      2'b01: mode_o[strap_eff[2] ? 4 : 5] = 1'b1;
      default: mode_o[strap_eff[2] ? 6 : 7] = 1'b1;
    endcase
  end

  assign boot_narrow_o = mode_o[1];

  always_comb begin
    if (mode_o[7])      pad_oe_o = '0;
    else if (mode_o[6]) pad_oe_o = pad_oe_i | IN_PAD_MASK;
    else                pad_oe_o = pad_oe_i;
  end

  always_comb begin
    if (!$isunknown({por_n, ntest0_n, ntest1_n, mode_o, pad_oe_i})) begin
      // R1
      mode_onehot_chk: assert ($onehot(mode_o));
      // R3
      bypass_sel_chk: assert (!(ntest0_n && !ntest1_n) || mode_o[3]);
      // R2
      normal_grp_chk: assert (!(ntest0_n && ntest1_n) || (mode_o[7:3] == 5'b0));
      // R9
      sys_hiz_chk: assert (!mode_o[7] || (pad_oe_o == '0));
      // R10
      pin_force_chk: assert (!mode_o[6] ||
        (((pad_oe_o & IN_PAD_MASK) == IN_PAD_MASK) &&
         ((pad_oe_o & ~IN_PAD_MASK) == (pad_oe_i & ~IN_PAD_MASK))));
      // R11
      oe_pass_chk: assert (mode_o[7] || mode_o[6] || (pad_oe_o == pad_oe_i));
      // R12
      narrow_flag_chk: assert (boot_narrow_o == (mode_o == 8'b0000_0010));
    end
  end

endmodule

// File: tb/strap_test_mode_bench.sv
`timescale 1ns/1ps
module strap_test_mode_bench;
  localparam int PADS = 16;
  localparam logic [PADS-1:0] MASK = 16'h0F0F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n, boot_a, boot_b, test_c, ntest0_n, ntest1_n;
  logic [PADS-1:0] pad_oe_i, pad_oe_o;
  logic [7:0] mode_o;
  logic boot_narrow_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  strap_test_mode #(.PADS(PADS), .IN_PAD_MASK(MASK)) u_strap_test_mode (
    .por_n(por_n), .boot_a(boot_a), .boot_b(boot_b), .test_c(test_c),
    .ntest0_n(ntest0_n), .ntest1_n(ntest1_n), .pad_oe_i(pad_oe_i),
    .mode_o(mode_o), .boot_narrow_o(boot_narrow_o), .pad_oe_o(pad_oe_o));

  function automatic logic [7:0] ref_mode(logic a, logic b, logic c, logic t0, logic t1);
    logic [7:0] m = 8'b0;
    if (t0 && t1)      m[a ? 2 : (b ? 1 : 0)] = 1'b1;
    else if (t0)       m[3] = 1'b1;
    else if (t1)       m[c ? 4 : 5] = 1'b1;
    else               m[c ? 6 : 7] = 1'b1;
    return m;
  endfunction

  function automatic logic [PADS-1:0] ref_oe(logic [7:0] m, logic [PADS-1:0] oe);
    if (m[7]) return '0;
    if (m[6]) return oe | MASK;
    return oe;
  endfunction

  function automatic string req_of(logic t0, logic t1);
    if (t0 && t1) return "R2";
    if (t0)       return "R3";
    if (t1)       return "R4";
    return "R5";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string ctx, logic a, logic b, logic c);
    logic [7:0] em;
    em = ref_mode(a, b, c, ntest0_n, ntest1_n);
    chk({ctx, " ", req_of(ntest0_n, ntest1_n), " R1 mode"}, {24'b0, mode_o}, {24'b0, em});
    chk({ctx, " R12 narrow"}, {31'b0, boot_narrow_o}, {31'b0, em[1]});
    chk(em[7] ? {ctx, " R9 oe"} : (em[6] ? {ctx, " R10 oe"} : {ctx, " R11 oe"}),
        {16'b0, pad_oe_o}, {16'b0, ref_oe(em, pad_oe_i)});
  endtask

  task automatic drive_rand();
    ntest0_n = 1'($urandom);
    ntest1_n = 1'($urandom);
    pad_oe_i = PADS'($urandom);
  endtask

  initial begin
    logic [2:0] lat;
    void'($urandom(32'h5eed_1234));
    por_n = 0; boot_a = 0; boot_b = 0; test_c = 0;
    ntest0_n = 1; ntest1_n = 1; pad_oe_i = '1;
    @(negedge clk);
    // reset state: wide boot, pass-through
    chk("R2 reset mode", {24'b0, mode_o}, 32'h1);
    chk("R11 reset oe", {16'b0, pad_oe_o}, 32'hFFFF);

    // R6: live straps while reset is low
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      {test_c, boot_b, boot_a} = 3'($urandom);
      drive_rand();
      @(negedge clk);
      check_all("R6", boot_a, boot_b, test_c);
    end

    // directed corners: system test with all enables on, pin test with all off
    @(posedge clk);
    test_c = 0; ntest0_n = 0; ntest1_n = 0; pad_oe_i = '1;
    @(negedge clk);
    chk("R9 all off", {16'b0, pad_oe_o}, 32'h0);
    @(posedge clk);
    test_c = 1; pad_oe_i = '0;
    @(negedge clk);
    chk("R10 mask only", {16'b0, pad_oe_o}, {16'b0, MASK});

    // R7 / R8: latch each strap combination, then disturb the pins
    for (int r = 0; r < 24; r++) begin
      @(posedge clk);
      por_n = 0;
      lat = (r < 8) ? 3'(r) : 3'($urandom);
      {test_c, boot_b, boot_a} = lat;
      @(posedge clk);
      por_n = 1;
      for (int i = 0; i < 60; i++) begin
        @(posedge clk);
        {test_c, boot_b, boot_a} = 3'($urandom);
        drive_rand();
        @(negedge clk);
        check_all("R7 R8", lat[0], lat[1], lat[2]);
      end
      // R7 directed: flip strap pins against the latched value, normal mode
      @(posedge clk);
      ntest0_n = 1; ntest1_n = 1;
      {test_c, boot_b, boot_a} = ~lat;
      @(negedge clk);
      chk("R7 frozen", {24'b0, mode_o}, {24'b0, ref_mode(lat[0], lat[1], lat[2], 1'b1, 1'b1)});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule